// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of up to four fans by timing their tachometer signals. Every channel counts ticks of a slow timebase (a 90 kHz rate, roughly 11.11 µs per tick, derived from the system clock by a divider) across a configurable number of consecutive rising tach edges. The result is a 16-bit period count per channel. A larger count means a slower fan.

A host fetches each result as two bytes through a one-cycle register read port. Reading the low byte locks that channel's value until the high byte has been read, so the two halves always belong to the same measurement. A measurement that finishes while the channel is locked is parked and becomes visible once the high byte is read.

A channel shows zero from reset until its first measurement lands. A channel whose fan is stalled, missing or repurposed saturates and reports all ones.

Top module: `fan_tach_meter`

## Requirements
- R1: The period count advances by one for every TICK_DIV system clocks. With TICK_DIV=1, a window of N edge intervals of P clocks each reports N*P.
- R2: A window spans a set number of consecutive rising-edge intervals; this number is 2 after reset. Each completed window publishes its count and immediately starts the next window from the closing edge.
- R3: A write strobe on `cfg_we` loads the per-channel window length from `cfg_ppw`, 3 bits per channel with channel k in bits [3k+2:3k]. A length of 0 behaves as 1.
- R4: From reset until a channel's first result is published, both of its bytes read 0x00.
- R5: If 0xFFFF ticks pass without a window completing, including when no edge ever arrives, the channel publishes 0xFFFF and re-arms on the next edge. The counter never wraps.
- R6: Reading a channel's low byte freezes its 16-bit value; later measurements do not change what either byte returns until that channel's high byte is read.
- R7: The newest measurement that completes while a channel is frozen is applied when the high byte is read, so the next read returns it.
- R8: `rd_addr` bit 0 selects the byte (0 = bits 7:0, 1 = bits 15:8) and bits 2:1 select the channel. `rd_data` carries the byte in the cycle after `rd_en` and holds it while `rd_en` is low.
- R9: Channels measure, freeze and saturate independently of one another.
- R10: Each tach input passes through a two-flop synchroniser, and only rising edges count. The result does not depend on the pulse's high time, down to a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tach_in | input | NUM_CH | Raw tachometer inputs, one per channel |
| cfg_we | input | 1 | Window-length write strobe |
| cfg_ppw | input | NUM_CH*PPW_W | Window lengths in edges, PPW_W bits per channel |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | CH_W+1 | {channel, byte select} |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |

## Verification
A read byte appears one cycle after its strobe. The bench therefore raises `rd_en` on a falling edge and samples `rd_data` at the next falling edge.

A new tach rate only shows up after the synchroniser delay, any unfinished old pulse, and at least one full window. Each scenario therefore waits four windows of the slowest channel plus the longest previous period before reading, and it compares against length × period with the timebase divider set to one.

A stall publishes about 65,536 ticks after the last edge. The stall check waits 67,000 cycles.

The freeze check reads the low byte, changes the rate, waits several new windows, and only then reads the high byte and the full value again.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic {
    ST_ARM = 1'b0,
    ST_RUN = 1'b1
  } tach_state_e;
endpackage

// File: rtl/tach_timebase.sv
module tach_timebase #(
  parameter int unsigned TICK_DIV = 1111
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q, div_d;

      always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + DW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = (div_q == LAST);

      assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tach_input_sync.sv
module tach_input_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_raw,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tach_raw;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tach_period_ch.sv
module tach_period_ch
  import fan_tach_pkg::*;
#(
  parameter int unsigned PPW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rise,
  input  logic [PPW_W-1:0] ppw,
  output logic             pub_vld,
  output logic [CNT_W-1:0] pub_val
);
  tach_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_start;
  logic [PPW_W-1:0] edges_q, edges_d, ppw_eff;
  logic             done;
  logic             pub_vld_q, pub_vld_d;
  logic [CNT_W-1:0] pub_val_q, pub_val_d;

  always_comb begin
    ppw_eff   = (ppw == '0) ? PPW_W'(1) : ppw;
    cnt_start = {{(CNT_W-1){1'b0}}, tick};
    done      = rise && (({1'b0, edges_q} + (PPW_W+1)'(1)) >= {1'b0, ppw_eff});
    state_d   = state_q;
    cnt_d     = cnt_q;
    edges_d   = edges_q;
    pub_vld_d = 1'b0;
    pub_val_d = pub_val_q;
    case (state_q)
      ST_ARM: begin
        if (rise) begin
          state_d = ST_RUN;
          cnt_d   = cnt_start;
          edges_d = '0;
        end else if (tick) begin
          if (cnt_q == CNT_MAX) begin
            pub_vld_d = 1'b1;
            pub_val_d = CNT_MAX;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        if (done) begin
          pub_vld_d = 1'b1;
          pub_val_d = cnt_q;
          cnt_d     = cnt_start;
          edges_d   = '0;
        end else begin
          if (rise) edges_d = edges_q + PPW_W'(1);
          if (tick) begin
            if (cnt_q == CNT_MAX) begin
              pub_vld_d = 1'b1;
              pub_val_d = CNT_MAX;
              state_d   = ST_ARM;
              cnt_d     = '0;
              edges_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ARM;
      cnt_q     <= '0;
      edges_q   <= '0;
      pub_vld_q <= 1'b0;
      pub_val_q <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      edges_q   <= edges_d;
      pub_vld_q <= pub_vld_d;
      pub_val_q <= pub_val_d;
    end
  end

  assign pub_vld = pub_vld_q;
  assign pub_val = pub_val_q;

  assert_pub_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pub_vld_q && pub_val_q != CNT_MAX) |-> $past(rise));
  assert_cnt_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_W'(1)) |=> (cnt_q >= $past(cnt_q) || cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/tach_read_freeze.sv
module tach_read_freeze
  import fan_tach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pub_vld,
  input  logic [CNT_W-1:0] pub_val,
  input  logic             lo_rd,
  input  logic             hi_rd,
  output logic [CNT_W-1:0] res
);
  logic [CNT_W-1:0] res_q, res_d, shd_q, shd_d;
  logic             frz_q, frz_d, pnd_q, pnd_d, hold;

  always_comb begin
    hold  = (frz_q || lo_rd) && !hi_rd;
    res_d = res_q;
    shd_d = shd_q;
    frz_d = frz_q;
    pnd_d = pnd_q;
    if (lo_rd) frz_d = 1'b1;
    if (hi_rd) begin
      frz_d = 1'b0;
      pnd_d = 1'b0;
      if (pnd_q) res_d = shd_q;
    end
    if (pub_vld) begin
      if (hold) begin
        shd_d = pub_val;
        pnd_d = 1'b1;
      end else begin
        res_d = pub_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      shd_q <= '0;
      frz_q <= 1'b0;
      pnd_q <= 1'b0;
    end else begin
      res_q <= res_d;
      shd_q <= shd_d;
      frz_q <= frz_d;
      pnd_q <= pnd_d;
    end
  end

  assign res = res_q;

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !hi_rd) |=> $stable(res_q));
  assert_pend_needs_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_q |-> frz_q);
  assert_release_applies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && pnd_q && !pub_vld) |=> (res_q == $past(shd_q)));
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned PPW_W    = 3,
  parameter int unsigned PPW_RST  = 2,
  parameter int unsigned TICK_DIV = 1111,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ADDR_W  = CH_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       tach_in,
  input  logic                    cfg_we,
  input  logic [NUM_CH*PPW_W-1:0] cfg_ppw,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                    tick;
  logic [NUM_CH*PPW_W-1:0] ppw_q, ppw_d;
  logic [CH_W-1:0]         rd_ch;
  logic                    rd_hi;
  logic [CNT_W-1:0]        res_all [NUM_CH];
  logic [CNT_W-1:0]        sel_res;
  logic [BYTE_W-1:0]       rd_data_q, rd_data_d;

  assign rd_ch = rd_addr[ADDR_W-1:1];
  assign rd_hi = rd_addr[0];

  always_comb begin
    ppw_d = cfg_we ? cfg_ppw : ppw_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ppw_q <= {NUM_CH{PPW_W'(PPW_RST)}};
    else             ppw_q <= ppw_d;
  end

  tach_timebase #(.TICK_DIV(TICK_DIV)) i_timebase (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic             rise, pub_vld, lo_rd, hi_rd;
      logic [CNT_W-1:0] pub_val;

      assign lo_rd = rd_en && !rd_hi && (rd_ch == CH_W'(i));
      assign hi_rd = rd_en &&  rd_hi && (rd_ch == CH_W'(i));

      tach_input_sync i_sync (
        .clk(clk), .rst_n(rst_sync_n), .tach_raw(tach_in[i]), .rise(rise)
      );

      tach_period_ch #(.PPW_W(PPW_W)) i_period (
        .clk(clk), .rst_n(rst_sync_n), .tick(tick), .rise(rise),
        .ppw(ppw_q[i*PPW_W +: PPW_W]), .pub_vld(pub_vld), .pub_val(pub_val)
      );

      tach_read_freeze i_freeze (
        .clk(clk), .rst_n(rst_sync_n), .pub_vld(pub_vld), .pub_val(pub_val),
        .lo_rd(lo_rd), .hi_rd(hi_rd), .res(res_all[i])
      );
    end
  endgenerate

  always_comb begin
    sel_res = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_ch == CH_W'(k)) sel_res = res_all[k];
    end
    rd_data_d = rd_hi ? sel_res[CNT_W-1:BYTE_W] : sel_res[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_data_q <= '0;
    else if (rd_en)   rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_data_q));
endmodule

// File: tb/test_fan_tach_meter.sv
module test_fan_tach_meter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  typedef struct packed {
    logic [2:0]  ppw;
    logic [15:0] p0;
    logic [15:0] p1;
    logic [15:0] p2;
    logic [15:0] p3;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 16'd100,  16'd50,  16'd37,  16'd200},
    '{3'd3, 16'd80,   16'd90,  16'd100, 16'd110},
    '{3'd4, 16'd250,  16'd20,  16'd64,  16'd129},
    '{3'd0, 16'd300,  16'd7,   16'd255, 16'd256},
    '{3'd2, 16'd1000, 16'd500, 16'd33,  16'd45}
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] tach;
  logic           cfg_we;
  logic [11:0]    cfg_ppw;
  logic           rd_en;
  logic [2:0]     rd_addr;
  logic [7:0]     rd_data;

  int per_a [NCH];
  int hi_a  [NCH];
  int total = 0;
  int bad   = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_tach_meter #(.NUM_CH(NCH), .PPW_W(3), .PPW_RST(2), .TICK_DIV(1)) i_fan_tach_meter (
    .clk(clk), .rst_n(rst_n), .tach_in(tach), .cfg_we(cfg_we), .cfg_ppw(cfg_ppw),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_gen
      logic t = 1'b0;
      assign tach[g] = t;
      initial begin : gen_loop
        int h;
        forever begin
          if (per_a[g] <= 1) begin
            t = 1'b0;
            @(negedge clk);
          end else begin
            h = (hi_a[g] == 0) ? per_a[g] / 2 : hi_a[g];
            t = 1'b1;
            repeat (h) @(negedge clk);
            t = 1'b0;
            repeat (per_a[g] - h) @(negedge clk);
          end
        end
      end
    end
  endgenerate

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input int ch, input bit hi, output logic [7:0] d);
    rd_en   = 1'b1;
    rd_addr = {ch[1:0], hi};
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_byte(ch, 1'b0, lo);
    rd_byte(ch, 1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic set_ppw(input int n);
    cfg_we  = 1'b1;
    cfg_ppw = {4{n[2:0]}};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ppw = '0; rd_en = 1'b0; rd_addr = '0;
    for (int i = 0; i < NCH; i++) begin per_a[i] = 0; hi_a[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: zero before any measurement
    for (int c = 0; c < NCH; c++) begin
      rd16(c, v);
      check("R4 reset value", v, 16'h0000);
    end

    // R2: default window of two edges
    per_a[0] = 100; per_a[1] = 120; per_a[2] = 140; per_a[3] = 160;
    repeat (4*2*160 + 200) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      rd16(c, v);
      check("R2 default window", v, 16'(2 * per_a[c]));
    end

    // R1 R3 R8 R9: vector table
    for (int k = 0; k < NVEC; k++) begin
      int mx;
      set_ppw(int'(VECS[k].ppw));
      per_a[0] = VECS[k].p0; per_a[1] = VECS[k].p1;
      per_a[2] = VECS[k].p2; per_a[3] = VECS[k].p3;
      mx = 0;
      for (int c = 0; c < NCH; c++) if (per_a[c] > mx) mx = per_a[c];
      repeat (4 * eff(int'(VECS[k].ppw)) * mx + 1100) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        rd16(c, v);
        check("R1/R3/R8/R9 table", v, 16'(eff(int'(VECS[k].ppw)) * per_a[c]));
      end
    end

    // R6 R7: freeze on low byte, release on high byte
    set_ppw(1);
    per_a[0] = 100;
    repeat (2500) @(negedge clk);
    rd_byte(0, 1'b0, b);
    check("R6 low byte at freeze", {8'h00, b}, 16'h0064);
    per_a[0] = 300;
    repeat (2500) @(negedge clk);
    rd_byte(0, 1'b1, b);
    check("R6 high byte still frozen", {8'h00, b}, 16'h0000);
    rd16(0, v);
    check("R7 parked value applied", v, 16'd300);

    // R10: pulse high time does not matter
    per_a[2] = 90; hi_a[2] = 89;
    per_a[3] = 90; hi_a[3] = 1;
    repeat (2500) @(negedge clk);
    rd16(2, v);
    check("R10 long high", v, 16'd90);
    rd16(3, v);
    check("R10 one-clock high", v, 16'd90);

    // R5: stall on channel 2, R9 others unaffected
    per_a[2] = 0;
    repeat (67000) @(negedge clk);
    rd16(2, v);
    check("R5 stall saturates", v, 16'hFFFF);
    rd16(3, v);
    check("R9 neighbour unaffected", v, 16'd90);
    rd16(0, v);
    check("R9 channel 0 running", v, 16'd300);

    summary();
  end
endmodule